// File: doc/BRIEF.md
# Decode-Time Branch Redirect Checker

This block sits at the exit of an instruction decode stage. Each cycle it sees a group of up to `SLOTS` instructions in slot order, oldest first. Each instruction arrives with its predecode attributes: control-transfer, direct and unconditional flags, the computed target, the predicted target, the predicted-taken bit and a no-source-operand flag. Direct unconditional branches are settled here, before execute. When the computed target disagrees with the prediction, the block cuts the group short after that instruction and corrects the instruction's predicted target. It marks younger same-thread instructions as squashed and, one cycle later, presents a one-cycle redirect record for fetch.

An instruction predicted taken that is not a control transfer is treated as a control misprediction. It cuts the group and raises a redirect in the same way. Instructions with no source operands leave marked ready to issue. Three running counters record resolved branches, target mismatches and control mispredictions.

Top module: `dec_redirect_chk`

## Requirements
- R1: `cnt_res` rises by the number of emitted slots that are valid, control, direct and unconditional, one clock after the group is presented.
- R2: A resolved slot whose computed target differs from its predicted target is a target mismatch. It is emitted with `out_ptgt` equal to the computed target, and `cnt_mis` rises by one on the next clock.
- R3: The first offending slot of a group sets `rd_vld` for exactly the next cycle. In that cycle `rd_predbad` and `rd_squash` are 1, `rd_seq` and `rd_tid` are the offender's, and `rd_npc` is its computed target.
- R4: `rd_taken` is 1 exactly when the offender's next PC differs from its PC plus `INSN_BYTES`.
- R5: The offending slot is emitted and every later slot of the group has `out_vld` 0.
- R6: `out_squash[i]` is 1 when a redirect is raised and slot i is valid, has the offender's thread, and has a sequence number above the offender's, compared unsigned.
- R7: A valid slot with predicted-taken 1 and control 0 is an offender of kind control error. It gives `rd_ctlerr` 1, `rd_brmis` 0 and a one-step rise of `cnt_err`.
- R8: `out_ready[i]` equals `out_vld[i]` AND the slot's no-source flag.
- R9: When several slots offend, only the lowest-indexed one drives the redirect and the counters.
- R10: During and right after reset, `rd_vld` and all counters are 0.
- R11: A matching direct unconditional branch, or any conditional or indirect control slot, raises no redirect and leaves `out_ptgt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | SLOTS | Slot holds an instruction |
| in_tid | input | SLOTS x TID_W | Thread of each slot |
| in_seq | input | SLOTS x SEQ_W | Sequence number of each slot |
| in_pc | input | SLOTS x PC_W | PC of each slot |
| in_npc | input | SLOTS x PC_W | Next PC of each slot |
| in_tgt | input | SLOTS x PC_W | Computed branch target |
| in_ptgt | input | SLOTS x PC_W | Predicted target |
| in_ctrl | input | SLOTS | Control transfer |
| in_dir | input | SLOTS | Direct target |
| in_unc | input | SLOTS | Unconditional |
| in_ptkn | input | SLOTS | Predicted taken |
| in_nosrc | input | SLOTS | No source operands |
| out_vld | output | SLOTS | Slot emitted to the next stage |
| out_ptgt | output | SLOTS x PC_W | Predicted target after correction |
| out_ready | output | SLOTS | Emitted and ready to issue |
| out_squash | output | SLOTS | Slot marked squashed |
| rd_vld | output | 1 | Redirect record valid |
| rd_brmis | output | 1 | Redirect caused by target mismatch |
| rd_ctlerr | output | 1 | Redirect caused by taken non-control |
| rd_predbad | output | 1 | Prediction-incorrect flag |
| rd_squash | output | 1 | Squash request flag |
| rd_tid | output | TID_W | Offender thread |
| rd_seq | output | SEQ_W | Offender sequence number |
| rd_npc | output | PC_W | Fetch restart address |
| rd_taken | output | 1 | Offender's next PC is non-sequential |
| cnt_res | output | CNT_W | Resolved branch count |
| cnt_mis | output | CNT_W | Target mismatch count |
| cnt_err | output | CNT_W | Control misprediction count |

## Verification
On every cycle, the assertions check four things. A counter changes only alongside a redirect of the matching kind. A redirect always follows a group that emitted an offender and carries its fixed flags. At most one emitted slot offends. Ready never appears on a slot that was not emitted. Only the bench scenarios can show the values themselves: the truncation point, the corrected target, which slots are squashed by thread and sequence number, the taken bit, the oldest-offender choice between two mismatches, and that the record drops after one cycle.

// File: rtl/dec_redirect_chk.sv
module dec_redirect_chk #(
  parameter int SLOTS      = 4,
  parameter int PC_W       = 32,
  parameter int SEQ_W      = 16,
  parameter int TID_W      = 2,
  parameter int CNT_W      = 16,
  parameter int INSN_BYTES = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [SLOTS-1:0]                 in_vld,
  input  logic [SLOTS-1:0][TID_W-1:0]      in_tid,
  input  logic [SLOTS-1:0][SEQ_W-1:0]      in_seq,
  input  logic [SLOTS-1:0][PC_W-1:0]       in_pc,
  input  logic [SLOTS-1:0][PC_W-1:0]       in_npc,
  input  logic [SLOTS-1:0][PC_W-1:0]       in_tgt,
  input  logic [SLOTS-1:0][PC_W-1:0]       in_ptgt,
  input  logic [SLOTS-1:0]                 in_ctrl,
  input  logic [SLOTS-1:0]                 in_dir,
  input  logic [SLOTS-1:0]                 in_unc,
  input  logic [SLOTS-1:0]                 in_ptkn,
  input  logic [SLOTS-1:0]                 in_nosrc,
  output logic [SLOTS-1:0]                 out_vld,
  output logic [SLOTS-1:0][PC_W-1:0]       out_ptgt,
  output logic [SLOTS-1:0]                 out_ready,
  output logic [SLOTS-1:0]                 out_squash,
  output logic                             rd_vld,
  output logic                             rd_brmis,
  output logic                             rd_ctlerr,
  output logic                             rd_predbad,
  output logic                             rd_squash,
  output logic [TID_W-1:0]                 rd_tid,
  output logic [SEQ_W-1:0]                 rd_seq,
  output logic [PC_W-1:0]                  rd_npc,
  output logic                             rd_taken,
  output logic [CNT_W-1:0]                 cnt_res,
  output logic [CNT_W-1:0]                 cnt_mis,
  output logic [CNT_W-1:0]                 cnt_err
);

  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  logic [SLOTS-1:0] resolve, mis, bad, off, sel;
  logic             blk, any_off;
  logic [TID_W-1:0] o_tid;
  logic [SEQ_W-1:0] o_seq;
  logic [PC_W-1:0]  o_tgt, o_pc, o_npc;
  logic             o_mis;

  always_comb begin
    blk     = 1'b0;
    out_vld = '0;
    sel     = '0;
    for (int i = 0; i < SLOTS; i++) begin
      resolve[i] = in_vld[i] & in_ctrl[i] & in_dir[i] & in_unc[i];
      mis[i]     = resolve[i] && (in_tgt[i] != in_ptgt[i]);
      bad[i]     = in_vld[i] & in_ptkn[i] & ~in_ctrl[i];
      off[i]     = mis[i] | bad[i];
      out_vld[i] = in_vld[i] & ~blk;
      sel[i]     = off[i] & ~blk;
      blk        = blk | off[i];
    end
  end

  always_comb begin
    o_tid = '0; o_seq = '0; o_tgt = '0; o_pc = '0; o_npc = '0; o_mis = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (sel[i]) begin
        o_tid = o_tid | in_tid[i];
        o_seq = o_seq | in_seq[i];
        o_tgt = o_tgt | in_tgt[i];
        o_pc  = o_pc  | in_pc[i];
        o_npc = o_npc | in_npc[i];
        o_mis = o_mis | mis[i];
      end
    end
  end

  assign any_off = |sel;

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_slot
      assign out_ptgt[g]   = mis[g] ? in_tgt[g] : in_ptgt[g];
      assign out_ready[g]  = out_vld[g] & in_nosrc[g];
      assign out_squash[g] = any_off & in_vld[g] & (in_tid[g] == o_tid) & (in_seq[g] > o_seq);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld     <= 1'b0;
      rd_brmis   <= 1'b0;
      rd_ctlerr  <= 1'b0;
      rd_predbad <= 1'b0;
      rd_squash  <= 1'b0;
      rd_tid     <= '0;
      rd_seq     <= '0;
      rd_npc     <= '0;
      rd_taken   <= 1'b0;
      cnt_res    <= '0;
      cnt_mis    <= '0;
      cnt_err    <= '0;
    end else begin
      rd_vld     <= any_off;
      rd_brmis   <= any_off & o_mis;
      rd_ctlerr  <= any_off & ~o_mis;
      rd_predbad <= any_off;
      rd_squash  <= any_off;
      rd_tid     <= o_tid;
      rd_seq     <= o_seq;
      rd_npc     <= o_tgt;
      rd_taken   <= any_off && (o_npc != o_pc + STEP);
      cnt_res    <= cnt_res + CNT_W'($countones(resolve & out_vld));
      cnt_mis    <= cnt_mis + CNT_W'(any_off & o_mis);
      cnt_err    <= cnt_err + CNT_W'(any_off & ~o_mis);
    end
  end

  a_r2_mis_cnt: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt_mis) |-> (rd_vld && rd_brmis));

  a_r7_err_cnt: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt_err) |-> (rd_vld && rd_ctlerr));

  a_r3_flags: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> (rd_predbad && rd_squash && (rd_brmis != rd_ctlerr)));

  a_r3_cause: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> $past(|(out_vld & off)));

  a_r5_single_off: assert property (@(posedge clk) disable iff (rst)
    $countones(out_vld & off) <= 1);

  a_r8_ready: assert property (@(posedge clk) disable iff (rst)
    (out_ready & ~out_vld) == '0);

endmodule

// File: tb/sim_dec_redirect_chk.sv
module sim_dec_redirect_chk;
  localparam int CLK_PERIOD = 10;
  localparam int S = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [S-1:0]         in_vld, in_ctrl, in_dir, in_unc, in_ptkn, in_nosrc;
  logic [S-1:0][1:0]    in_tid;
  logic [S-1:0][15:0]   in_seq;
  logic [S-1:0][31:0]   in_pc, in_npc, in_tgt, in_ptgt;
  logic [S-1:0]         out_vld, out_ready, out_squash;
  logic [S-1:0][31:0]   out_ptgt;
  logic rd_vld, rd_brmis, rd_ctlerr, rd_predbad, rd_squash, rd_taken;
  logic [1:0]  rd_tid;
  logic [15:0] rd_seq;
  logic [31:0] rd_npc;
  logic [15:0] cnt_res, cnt_mis, cnt_err;

  int checks = 0, fails = 0;
  int e_res = 0, e_mis = 0, e_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_redirect_chk u0 (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr();
    in_vld = '0; in_ctrl = '0; in_dir = '0; in_unc = '0; in_ptkn = '0; in_nosrc = '0;
    in_tid = '0; in_seq = '0; in_pc = '0; in_npc = '0; in_tgt = '0; in_ptgt = '0;
  endtask

  task automatic put(int i, logic [1:0] tid, logic [15:0] seq, logic [31:0] pc,
                     logic [31:0] npc, logic [31:0] tgt, logic [31:0] ptgt,
                     logic c, logic d, logic u, logic pt, logic ns);
    in_vld[i] = 1'b1; in_tid[i] = tid; in_seq[i] = seq; in_pc[i] = pc;
    in_npc[i] = npc; in_tgt[i] = tgt; in_ptgt[i] = ptgt;
    in_ctrl[i] = c; in_dir[i] = d; in_unc[i] = u; in_ptkn[i] = pt; in_nosrc[i] = ns;
  endtask

  // inputs are applied just after a falling edge; registered results are read after the next falling edge
  task automatic step_and_clear();
    @(negedge clk); clr(); #1;
  endtask

  task automatic chk_counters(string req);
    chk({req, " cnt_res"}, 64'(cnt_res), 64'(e_res));
    chk({req, " cnt_mis"}, 64'(cnt_mis), 64'(e_mis));
    chk({req, " cnt_err"}, 64'(cnt_err), 64'(e_err));
  endtask

  task automatic t_reset();
    chk("R10 rd_vld", 64'(rd_vld), 0);
    chk_counters("R10");
  endtask

  task automatic t_plain();
    @(negedge clk); clr();
    put(0, 0, 1, 32'h100, 32'h104, 0, 0, 0, 0, 0, 0, 0);
    put(1, 0, 2, 32'h104, 32'h108, 0, 0, 0, 0, 0, 0, 1);
    put(2, 0, 3, 32'h108, 32'h10c, 0, 0, 0, 0, 0, 0, 0);
    put(3, 0, 4, 32'h10c, 32'h110, 0, 0, 0, 0, 0, 0, 1);
    #1;
    chk("R8 out_vld", 64'(out_vld), 64'hf);
    chk("R8 out_ready", 64'(out_ready), 64'ha);
    chk("R6 no squash", 64'(out_squash), 0);
    step_and_clear();
    chk("R11 plain no rd", 64'(rd_vld), 0);
    chk_counters("R11 plain");
  endtask

  task automatic t_match();
    @(negedge clk); clr();
    put(0, 1, 10, 32'h200, 32'h300, 32'h300, 32'h300, 1, 1, 1, 1, 0);
    put(1, 1, 11, 32'h300, 32'h304, 32'h400, 32'h500, 1, 1, 0, 0, 0);
    put(2, 1, 12, 32'h304, 32'h600, 32'h600, 32'h600, 1, 1, 1, 1, 0);
    put(3, 1, 13, 32'h600, 32'h604, 32'h700, 32'h800, 1, 0, 1, 1, 0);
    #1;
    chk("R11 all emitted", 64'(out_vld), 64'hf);
    chk("R11 ptgt kept slot1", 64'(out_ptgt[1]), 64'h500);
    chk("R11 ptgt kept slot3", 64'(out_ptgt[3]), 64'h800);
    step_and_clear();
    e_res += 2;
    chk("R11 match no rd", 64'(rd_vld), 0);
    chk_counters("R1 match");
  endtask

  task automatic t_mis();
    @(negedge clk); clr();
    put(0, 1, 19, 32'h1000, 32'h1004, 0, 0, 0, 0, 0, 0, 0);
    put(1, 1, 20, 32'h1004, 32'h2000, 32'h2000, 32'h3000, 1, 1, 1, 1, 1);
    put(2, 1, 21, 32'h2000, 32'h2004, 0, 0, 0, 0, 0, 0, 0);
    put(3, 0, 22, 32'h2004, 32'h2008, 0, 0, 0, 0, 0, 0, 0);
    #1;
    chk("R5 cut after offender", 64'(out_vld), 64'h3);
    chk("R2 corrected ptgt", 64'(out_ptgt[1]), 64'h2000);
    chk("R6 squash same tid", 64'(out_squash), 64'h4);
    chk("R8 ready on offender", 64'(out_ready), 64'h2);
    step_and_clear();
    e_res += 1; e_mis += 1;
    chk("R3 rd_vld", 64'(rd_vld), 1);
    chk("R3 rd_predbad", 64'(rd_predbad), 1);
    chk("R3 rd_squash", 64'(rd_squash), 1);
    chk("R3 rd_seq", 64'(rd_seq), 20);
    chk("R3 rd_tid", 64'(rd_tid), 1);
    chk("R3 rd_npc", 64'(rd_npc), 64'h2000);
    chk("R2 rd_brmis", 64'(rd_brmis), 1);
    chk("R4 rd_taken", 64'(rd_taken), 1);
    chk_counters("R2 mis");
    step_and_clear();
    chk("R3 one cycle only", 64'(rd_vld), 0);
  endtask

  task automatic t_seq_taken();
    @(negedge clk); clr();
    put(2, 2, 40, 32'h500, 32'h504, 32'h504, 32'h900, 1, 1, 1, 0, 0);
    #1;
    chk("R5 slot2 offender", 64'(out_vld), 64'h4);
    step_and_clear();
    e_res += 1; e_mis += 1;
    chk("R4 sequential not taken", 64'(rd_taken), 0);
    chk("R3 rd_seq", 64'(rd_seq), 40);
    chk_counters("R2 seq");
  endtask

  task automatic t_ctlerr();
    @(negedge clk); clr();
    put(0, 3, 50, 32'h700, 32'h800, 32'h704, 32'h800, 0, 0, 0, 1, 0);
    put(1, 3, 51, 32'h704, 32'h708, 0, 0, 0, 0, 0, 0, 1);
    put(2, 3, 49, 32'h708, 32'h70c, 0, 0, 0, 0, 0, 0, 0);
    #1;
    chk("R7 cut after bad", 64'(out_vld), 64'h1);
    chk("R6 squash larger seq only", 64'(out_squash), 64'h2);
    step_and_clear();
    e_err += 1;
    chk("R7 rd_vld", 64'(rd_vld), 1);
    chk("R7 rd_ctlerr", 64'(rd_ctlerr), 1);
    chk("R7 rd_brmis", 64'(rd_brmis), 0);
    chk("R7 rd_npc", 64'(rd_npc), 64'h704);
    chk_counters("R7 ctlerr");
  endtask

  task automatic t_oldest();
    @(negedge clk); clr();
    put(0, 0, 60, 32'ha00, 32'ha04, 0, 0, 0, 0, 0, 0, 0);
    put(1, 0, 61, 32'ha04, 32'hb00, 32'hb00, 32'hc00, 1, 1, 1, 1, 0);
    put(2, 0, 62, 32'hb00, 32'hb04, 0, 0, 0, 0, 0, 0, 0);
    put(3, 0, 63, 32'hb04, 32'hd00, 32'hd00, 32'he00, 1, 1, 1, 1, 0);
    #1;
    chk("R9 cut at first", 64'(out_vld), 64'h3);
    chk("R9 later ptgt untouched? squash", 64'(out_squash), 64'hc);
    step_and_clear();
    e_res += 1; e_mis += 1;
    chk("R9 rd_seq oldest", 64'(rd_seq), 61);
    chk("R9 rd_npc oldest", 64'(rd_npc), 64'hb00);
    chk_counters("R9 oldest");
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    @(negedge clk); rst = 1'b0; #1;
    t_reset();
    t_plain();
    t_match();
    t_mis();
    t_seq_taken();
    t_ctlerr();
    t_oldest();
    finish_run();
  end
endmodule